// File: doc/BRIEF.md
# Sequenced Grouped Neuron Array

This block evaluates a bank of single-layer neurons with identity activation. A flat array of signed 8-bit samples and a matching array of signed 8-bit weights are split into groups of consecutive lanes (eight groups of eight by default). Each group has its own 16-bit bias and its own 16-bit result register.

A one-hot sequencer visits the groups one per clock, in ascending address order. In each step one shared multiply/adder-tree datapath forms that group's dot product, adds the group's bias, clamps the result to the signed output range, and loads it into the group's result register.

A host holds the operands steady, pulses `start`, and waits for the one-cycle `done` flag. At that point every result register holds a fresh value, and the values stay there until the next run.

Top module: `grouped_neuron_seq`

## Requirements
- R1: Group g (0-based) uses samples and weights with lane indices 8g..8g+7; lane i sits at bits [8i+7:8i] of `x_flat` and `w_flat`.
- R2: Group g adds the bias at bits [16g+15:16g] of `bias_flat` and writes its result to bits [16g+15:16g] of `y_flat`; no other group reads that bias or writes that slot.
- R3: The state register is one-hot. While running, `grp_addr` shows the active group and steps 0,1,...,7, one step per clock; while idle, `grp_addr` reads 0.
- R4: A stored result equals the two's-complement sum of the group's eight sample×weight products plus its bias (identity activation), formed at full width.
- R5: A sum above 32767 is stored as 32767, and a sum below -32768 is stored as -32768.
- R6: A `start` pulse sampled while idle makes group 0 active in the next cycle.
- R7: `done` is high for exactly one cycle: the cycle after group 7 is active. In that same cycle the last result is visible and the machine is idle, so a `start` in that cycle is accepted.
- R8: A `start` pulse sampled while a run is active does not restart, stretch or repeat the run.
- R9: While idle, the result registers keep their values even when the operands change.
- R10: A synchronous reset, even in the middle of a run, clears every result register and `done`, and returns the machine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| x_flat | input | 512 | 64 signed 8-bit samples, lane i at [8i+7:8i] |
| w_flat | input | 512 | 64 signed 8-bit weights, lane i at [8i+7:8i] |
| bias_flat | input | 128 | 8 signed 16-bit biases, group g at [16g+15:16g] |
| y_flat | output | 128 | 8 signed 16-bit results, group g at [16g+15:16g] |
| done | output | 1 | One-cycle pulse at the end of a run |
| grp_addr | output | 3 | Active group address (0 while idle) |

## Verification
Two pairs of events can fall in the same cycle.

- The finishing `done` cycle and a fresh `start`. The bench asserts `start` in exactly the cycle where it sees `done`, then expects group 0 to be active at the next sample and the second run to produce its own results.
- A running group and a `start` pulse. The bench pokes `start` at a middle group and again at the last group. It judges the outcome by the unbroken address sequence, by `done` arriving on schedule, and by the address staying at 0 with no second `done` afterwards.

A reset asserted mid-run is also checked against the cleared outputs.

// File: rtl/gns_pkg.sv
package gns_pkg;

   // Behaviour when a group's full-width sum does not fit the output width.
   typedef enum logic {
      OVF_SATURATE = 1'b0,
      OVF_WRAP     = 1'b1
   } ovf_mode_e;

   function automatic int unsigned addr_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/gns_sequencer.sv
module gns_sequencer #(
   parameter int GROUPS = 8,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic [GROUPS:0]   state_oh,
   output logic [GROUPS-1:0] grp_sel,
   output logic [AW-1:0]     grp_addr,
   output logic              done
);

   // bit 0 = idle, bit k+1 = group k active
   logic [GROUPS:0] state_nx;

   always_comb begin
      state_nx    = '0;
      state_nx[0] = (state_oh[0] & ~start) | state_oh[GROUPS];
      state_nx[1] = state_oh[0] & start;
      for (int k = 2; k <= GROUPS; k++) begin
         state_nx[k] = state_oh[k-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_oh <= {{GROUPS{1'b0}}, 1'b1};
         done     <= 1'b0;
      end else begin
         state_oh <= state_nx;
         done     <= state_oh[GROUPS];
      end
   end

   assign grp_sel = state_oh[GROUPS:1];

   always_comb begin
      grp_addr = '0;
      for (int k = 0; k < GROUPS; k++) begin
         if (grp_sel[k]) grp_addr = grp_addr | AW'(k);
      end
   end

endmodule

// File: rtl/gns_mac_group.sv
module gns_mac_group
   import gns_pkg::*;
#(
   parameter int        LANES = 8,
   parameter int        DW    = 8,
   parameter int        BW    = 16,
   parameter int        OW    = 16,
   parameter ovf_mode_e OVF   = OVF_SATURATE
) (
   input  logic [LANES*DW-1:0] x_vec,
   input  logic [LANES*DW-1:0] w_vec,
   input  logic [BW-1:0]       bias,
   output logic [OW-1:0]       y
);

   localparam int LV    = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int PW    = 2 * DW;
   localparam int SW    = PW + LV;
   localparam int TW    = ((SW > BW) ? SW : BW) + 1;
   localparam int NODES = 2 * LANES - 1;

   if (OW > TW) begin : g_bad_ow
      $error("gns_mac_group: OW exceeds the full sum width");
   end

   // Heap-ordered adder tree: node i sums nodes 2i+1 and 2i+2,
   // leaves LANES-1 .. 2*LANES-2 hold the products.
   logic signed [SW-1:0] nd [NODES];

   for (genvar j = 0; j < LANES; j++) begin : g_mul
      assign nd[LANES-1+j] = SW'($signed(x_vec[j*DW +: DW]) * $signed(w_vec[j*DW +: DW]));
   end

   for (genvar i = 0; i < LANES - 1; i++) begin : g_add
      assign nd[i] = nd[2*i+1] + nd[2*i+2];
   end

   logic signed [TW-1:0] total;
   assign total = TW'(nd[0]) + TW'($signed(bias));

   if (OVF == OVF_SATURATE) begin : g_sat
      localparam logic signed [TW-1:0] MAXV = {{(TW-OW+1){1'b0}}, {(OW-1){1'b1}}};
      localparam logic signed [TW-1:0] MINV = {{(TW-OW+1){1'b1}}, {(OW-1){1'b0}}};
      always_comb begin
         if (total > MAXV)      y = MAXV[OW-1:0];
         else if (total < MINV) y = MINV[OW-1:0];
         else                   y = total[OW-1:0];
      end
   end else begin : g_wrap
      assign y = total[OW-1:0];
   end

endmodule

// File: rtl/grouped_neuron_seq.sv
module grouped_neuron_seq
   import gns_pkg::*;
#(
   parameter int        GROUPS = 8,
   parameter int        LANES  = 8,
   parameter int        DW     = 8,
   parameter int        BW     = 16,
   parameter int        OW     = 16,
   parameter ovf_mode_e OVF    = OVF_SATURATE,
   localparam int       AW     = addr_bits(GROUPS),
   localparam int       GW     = LANES * DW,
   localparam int       NX     = GROUPS * GW
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic [NX-1:0]        x_flat,
   input  logic [NX-1:0]        w_flat,
   input  logic [GROUPS*BW-1:0] bias_flat,
   output logic [GROUPS*OW-1:0] y_flat,
   output logic                 done,
   output logic [AW-1:0]        grp_addr
);

   if (GROUPS < 2) begin : g_bad_groups
      $error("grouped_neuron_seq: GROUPS must be at least 2");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("grouped_neuron_seq: LANES must be at least 2");
   end
   if (DW < 2 || BW < 2 || OW < 2) begin : g_bad_width
      $error("grouped_neuron_seq: widths must be at least 2");
   end

   logic [GROUPS:0]   state_oh;
   logic [GROUPS-1:0] grp_sel;

   gns_sequencer #(
      .GROUPS (GROUPS),
      .AW     (AW)
   ) i_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .state_oh (state_oh),
      .grp_sel  (grp_sel),
      .grp_addr (grp_addr),
      .done     (done)
   );

   // AND-OR operand selection driven by the one-hot group select
   logic [GW-1:0] x_grp;
   logic [GW-1:0] w_grp;
   logic [BW-1:0] b_grp;

   always_comb begin
      x_grp = '0;
      w_grp = '0;
      b_grp = '0;
      for (int g = 0; g < GROUPS; g++) begin
         x_grp = x_grp | (x_flat[g*GW +: GW]    & {GW{grp_sel[g]}});
         w_grp = w_grp | (w_flat[g*GW +: GW]    & {GW{grp_sel[g]}});
         b_grp = b_grp | (bias_flat[g*BW +: BW] & {BW{grp_sel[g]}});
      end
   end

   logic [OW-1:0] mac_y;

   gns_mac_group #(
      .LANES (LANES),
      .DW    (DW),
      .BW    (BW),
      .OW    (OW),
      .OVF   (OVF)
   ) i_mac (
      .x_vec (x_grp),
      .w_vec (w_grp),
      .bias  (b_grp),
      .y     (mac_y)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_out
      always_ff @(posedge clk) begin
         if (rst)             y_flat[g*OW +: OW] <= '0;
         else if (grp_sel[g]) y_flat[g*OW +: OW] <= mac_y;
      end
   end

endmodule

// File: rtl/gns_checker.sv
module gns_checker #(
   parameter int GROUPS = 8,
   parameter int OW     = 16,
   parameter int AW     = 3
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 start,
   input logic [GROUPS:0]      state_oh,
   input logic [AW-1:0]        grp_addr,
   input logic                 done,
   input logic [GROUPS*OW-1:0] y_flat
);

   // R3: exactly one state bit set
   a_r3_onehot_state: assert property (@(posedge clk) disable iff (rst)
      $onehot(state_oh));

   // R3: address steps by one between consecutive group states
   a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
      (!state_oh[0] && !state_oh[GROUPS]) |=> (grp_addr == AW'($past(grp_addr) + 1'b1)));

   // R6: start while idle enters group 0
   a_r6_start_enters: assert property (@(posedge clk) disable iff (rst)
      (state_oh[0] && start) |=> (state_oh[1] && grp_addr == '0));

   // R7: done lasts one cycle and follows the last group
   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
      state_oh[GROUPS] |=> (done && state_oh[0]));

   // R8: start during a run never re-enters group 0
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
      (start && !state_oh[0]) |=> !state_oh[1]);

   // R9: results stay put while idle
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
      state_oh[0] |=> $stable(y_flat));

   // R10: reset clears outputs and returns to idle
   a_r10_reset_clear: assert property (@(posedge clk)
      rst |=> (!done && y_flat == '0 && state_oh[0]));

endmodule

bind grouped_neuron_seq gns_checker #(
   .GROUPS (GROUPS),
   .OW     (OW),
   .AW     (AW)
) i_gns_checker (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .state_oh (state_oh),
   .grp_addr (grp_addr),
   .done     (done),
   .y_flat   (y_flat)
);

// File: tb/test_grouped_neuron_seq.sv
module test_grouped_neuron_seq;

   localparam int G = 8;
   localparam int L = 8;
   localparam int N = G * L;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               start = 1'b0;
   logic [N*8-1:0]     x_flat = '0;
   logic [N*8-1:0]     w_flat = '0;
   logic [G*16-1:0]    bias_flat = '0;
   logic [G*16-1:0]    y_flat;
   logic               done;
   logic [2:0]         grp_addr;

   int checks = 0;
   int errors = 0;

   logic [7:0]  xb [N];
   logic [7:0]  wb [N];
   logic [15:0] bb [G];
   int          saved [G];

   always #4 clk = ~clk;

   grouped_neuron_seq i_grouped_neuron_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .x_flat    (x_flat),
      .w_flat    (w_flat),
      .bias_flat (bias_flat),
      .y_flat    (y_flat),
      .done      (done),
      .grp_addr  (grp_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive();
      for (int i = 0; i < N; i++) begin
         x_flat[i*8 +: 8] = xb[i];
         w_flat[i*8 +: 8] = wb[i];
      end
      for (int g = 0; g < G; g++) bias_flat[g*16 +: 16] = bb[g];
   endtask

   function automatic int model(input int g);
      int s;
      s = int'($signed(bb[g]));
      for (int j = 0; j < L; j++) begin
         s += int'($signed(xb[g*L+j])) * int'($signed(wb[g*L+j]));
      end
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      return s;
   endfunction

   function automatic int yout(input int g);
      return int'($signed(y_flat[g*16 +: 16]));
   endfunction

   task automatic check_outputs(input string req);
      for (int g = 0; g < G; g++) begin
         chk(yout(g) == model(g), req, yout(g), model(g));
      end
   endtask

   task automatic randomize_ops();
      for (int i = 0; i < N; i++) begin
         xb[i] = 8'($urandom);
         wb[i] = 8'($urandom);
      end
      for (int g = 0; g < G; g++) bb[g] = 16'($urandom);
      drive();
   endtask

   // poke: group index at which start is pulsed (-1: none)
   // pre: start already asserted by the previous run's done cycle
   // chain: assert start in the done cycle and return
   task automatic run_seq(input int poke, input bit pre, input bit chain);
      if (!pre) begin
         @(negedge clk) start = 1'b1;
      end
      @(negedge clk) start = 1'b0;
      for (int k = 0; k < G; k++) begin
         chk(grp_addr == 3'(k), "R3 address sequence", int'(grp_addr), k);
         chk(done == 1'b0, "R7 done low while running", int'(done), 0);
         start = (k == poke);
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, "R7 done after last group", int'(done), 1);
      chk(grp_addr == 3'd0, "R3 idle address", int'(grp_addr), 0);
      check_outputs("R4 R1 R2 group results");
      if (chain) begin
         start = 1'b1;
         return;
      end
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
      if (poke >= 0) begin
         @(negedge clk);
         chk(grp_addr == 3'd0, "R8 no restart after ignored start", int'(grp_addr), 0);
         chk(done == 1'b0, "R8 no repeated done", int'(done), 0);
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin xb[i] = '0; wb[i] = '0; end
      for (int g = 0; g < G; g++) bb[g] = '0;
      drive();
      repeat (3) @(negedge clk);

      // R10: reset state
      for (int g = 0; g < G; g++) chk(yout(g) == 0, "R10 reset result", yout(g), 0);
      chk(done == 1'b0, "R10 reset done", int'(done), 0);
      chk(grp_addr == 3'd0, "R10 reset address", int'(grp_addr), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(grp_addr == 3'd0, "R6 stays idle without start", int'(grp_addr), 0);

      // R1 R2: distinct per-lane pattern so any misrouting shows
      for (int i = 0; i < N; i++) begin
         xb[i] = 8'(i + 1);
         wb[i] = 8'((i % L) + 1);
      end
      for (int g = 0; g < G; g++) bb[g] = 16'(g * 1000 - 3000);
      drive();
      run_seq(-1, 1'b0, 1'b0);

      // R5: saturation high, low and mixed
      for (int i = 0; i < N; i++) begin
         xb[i] = 8'h80;
         wb[i] = ((i / L) % 2 == 0) ? 8'h80 : 8'h7F;
      end
      for (int g = 0; g < G; g++) bb[g] = (g % 2 == 0) ? 16'h7FFF : 16'h8000;
      bb[6] = 16'h0000;
      for (int j = 0; j < L; j++) begin xb[6*L+j] = 8'd2; wb[6*L+j] = 8'hFD; end
      drive();
      run_seq(-1, 1'b0, 1'b0);
      chk(yout(0) == 32767, "R5 clamp high", yout(0), 32767);
      chk(yout(1) == -32768, "R5 clamp low", yout(1), -32768);
      chk(yout(6) == -48, "R5 in-range untouched", yout(6), -48);

      // R8: start poked mid-run and at the last group
      randomize_ops();
      run_seq(3, 1'b0, 1'b0);
      randomize_ops();
      run_seq(7, 1'b0, 1'b0);

      // R7 R6: start in the done cycle begins a new run
      randomize_ops();
      run_seq(-1, 1'b0, 1'b1);
      randomize_ops();
      run_seq(-1, 1'b1, 1'b0);

      // R9: operands change while idle, results hold
      for (int g = 0; g < G; g++) saved[g] = model(g);
      randomize_ops();
      repeat (5) @(negedge clk);
      for (int g = 0; g < G; g++) chk(yout(g) == saved[g], "R9 idle hold", yout(g), saved[g]);

      // R4: random operand sets
      for (int r = 0; r < 20; r++) begin
         randomize_ops();
         run_seq(-1, 1'b0, 1'b0);
      end

      // R10: reset in the middle of a run
      randomize_ops();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int g = 0; g < G; g++) chk(yout(g) == 0, "R10 mid-run reset result", yout(g), 0);
      chk(done == 1'b0, "R10 mid-run reset done", int'(done), 0);
      chk(grp_addr == 3'd0, "R10 mid-run reset address", int'(grp_addr), 0);
      @(negedge clk);
      chk(grp_addr == 3'd0, "R10 idle after reset", int'(grp_addr), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule